// File: doc/BRIEF.md
# Counter Overflow Flag Register

This block sits beside the top decade of a seven-digit decimal counter chain. The chain is full at 9,999,999, and the next count makes the top decade pulse its carry output. The block records that event and drives an overflow lamp. It also tells the display's zero-suppression logic that the true count is larger than what the digits show, so that leading zeros stay visible.

Capture happens in two stages. A carry edge sets a pre-stage flag at once. The visible indicator copies the pre-stage only when the latch strobe falls, so the lamp changes together with the newly latched digits. In manual counting mode, where no latch strobe arrives, the pre-stage drives the lamp straight away. A clear pulse returns both stages to the no-overflow state. All inputs are sampled on the system clock. Edges are found by comparing each input with its value on the previous clock.

Top module: `ovf_flag_reg`

## Requirements
- R1: After reset, `ovf_o` and `exceeds_o` are both low.
- R2: A carry edge (`carry_i` sampled 0 and then 1 on consecutive clocks) sets the pre-stage on that clock. With `manual_i` low, `ovf_o` does not rise on that edge.
- R3: A latch fall (`latch_i` sampled 1 and then 0 on consecutive clocks) loads the indicator with the pre-stage value held before that clock edge. Between latch falls the indicator does not change, except through clear.
- R4: With `manual_i` high, `ovf_o` is high from the clock edge that captures a carry edge, without any latch strobe.
- R5: With `manual_i` low, `ovf_o` follows only the indicator stage, so a pre-stage that is set but not yet released is not visible.
- R6: `clear_i` high at a clock edge zeroes both stages. Clear wins over a carry edge or a latch fall on the same edge.
- R7: Once set, each stage stays set through further carry edges and latch falls until a clear.
- R8: `exceeds_o` equals `ovf_o` on every cycle.
- R9: A latch fall with no carry edge since the last clear or reset leaves `ovf_o` low.
- R10: When a carry edge and a latch fall land on the same clock edge, the indicator takes the old (clear) pre-stage value. The overflow appears at the next latch fall.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| carry_i | input | 1 | Carry/full pulse from the top decade |
| latch_i | input | 1 | Latch strobe; its falling edge releases the flag |
| clear_i | input | 1 | Synchronous clear of both stages |
| manual_i | input | 1 | Manual counting mode select |
| ovf_o | output | 1 | Overflow indicator, active high |
| exceeds_o | output | 1 | Count exceeds display; disables leading-zero blanking |

## Verification
The hardest case to reach is a carry edge and a latch fall on the same clock edge, which tests whether release uses the pre-stage value from before that edge. The stimulus arranges it by raising `latch_i` one cycle early and then dropping it in the same cycle that `carry_i` rises. It then checks that the lamp stays dark until a second strobe. A second hard case is clear arriving on the same edge as a latch fall while the pre-stage is already set. The stimulus builds the pre-stage first and then issues both inputs together.

// File: rtl/ovf_pkg.sv
package ovf_pkg;
  typedef enum logic {EDGE_RISE = 1'b0, EDGE_FALL = 1'b1} edge_kind_e;
endpackage

// File: rtl/ovf_edge_det.sv
module ovf_edge_det
  import ovf_pkg::*;
#(
  parameter edge_kind_e KIND = EDGE_RISE
) (
  input  logic clk,
  input  logic rst_n,
  input  logic sig_i,
  output logic pulse_o
);
  logic prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= 1'b0;
    else        prev_q <= sig_i;
  end

  generate
    if (KIND == EDGE_RISE) begin : g_rise
      assign pulse_o = sig_i & ~prev_q;
    end else begin : g_fall
      assign pulse_o = ~sig_i & prev_q;
    end
  endgenerate
endmodule

// File: rtl/ovf_capture.sv
module ovf_capture (
  input  logic clk,
  input  logic rst_n,
  input  logic set_i,
  input  logic clr_i,
  output logic flag_o
);
  logic flag_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     flag_q <= 1'b0;
    else if (clr_i) flag_q <= 1'b0;
    else if (set_i) flag_q <= 1'b1;
  end

  assign flag_o = flag_q;

  p_capture_sets_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (set_i && !clr_i) |=> flag_q);
  p_capture_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_q && !clr_i) |=> flag_q);
  p_capture_clear_r6: assert property (@(posedge clk) disable iff (!rst_n)
    clr_i |=> !flag_q);
endmodule

// File: rtl/ovf_release.sv
module ovf_release (
  input  logic clk,
  input  logic rst_n,
  input  logic load_i,
  input  logic d_i,
  input  logic clr_i,
  output logic flag_o
);
  logic flag_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      flag_q <= 1'b0;
    else if (clr_i)  flag_q <= 1'b0;
    else if (load_i) flag_q <= d_i;
  end

  assign flag_o = flag_q;

  p_release_loads_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (load_i && !clr_i) |=> (flag_q == $past(d_i)));
  p_release_holds_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!load_i && !clr_i) |=> $stable(flag_q));
  p_release_clear_r6: assert property (@(posedge clk) disable iff (!rst_n)
    clr_i |=> !flag_q);
endmodule

// File: rtl/ovf_flag_reg.sv
module ovf_flag_reg
  import ovf_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic carry_i,
  input  logic latch_i,
  input  logic clear_i,
  input  logic manual_i,
  output logic ovf_o,
  output logic exceeds_o
);
  logic carry_edge;
  logic latch_fall;
  logic pre_flag;
  logic shown_flag;

  ovf_edge_det #(.KIND(EDGE_RISE)) u_carry_edge (
    .clk(clk), .rst_n(rst_n), .sig_i(carry_i), .pulse_o(carry_edge)
  );

  ovf_edge_det #(.KIND(EDGE_FALL)) u_latch_edge (
    .clk(clk), .rst_n(rst_n), .sig_i(latch_i), .pulse_o(latch_fall)
  );

  ovf_capture u_pre (
    .clk(clk), .rst_n(rst_n), .set_i(carry_edge), .clr_i(clear_i),
    .flag_o(pre_flag)
  );

  ovf_release u_show (
    .clk(clk), .rst_n(rst_n), .load_i(latch_fall), .d_i(pre_flag),
    .clr_i(clear_i), .flag_o(shown_flag)
  );

  assign ovf_o     = shown_flag | (manual_i & pre_flag);
  assign exceeds_o = ovf_o;

  p_manual_shows_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (manual_i && pre_flag) |-> ovf_o);
  p_auto_hides_pre_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (!manual_i && !shown_flag) |-> !ovf_o);
  p_no_overflow_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !pre_flag |-> !shown_flag);
  p_exceeds_tracks_r8: assert property (@(posedge clk) disable iff (!rst_n)
    exceeds_o == ovf_o);
endmodule

// File: tb/ovf_flag_reg_tb_top.sv
module ovf_flag_reg_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic carry_i = 1'b0;
  logic latch_i = 1'b0;
  logic clear_i = 1'b0;
  logic manual_i = 1'b0;
  logic ovf_o;
  logic exceeds_o;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  ovf_flag_reg dut_i (
    .clk(clk), .rst_n(rst_n), .carry_i(carry_i), .latch_i(latch_i),
    .clear_i(clear_i), .manual_i(manual_i), .ovf_o(ovf_o), .exceeds_o(exceeds_o)
  );

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic check(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %b expected %b", req, act, exp);
    end
    checks++;
    if (exceeds_o !== ovf_o) begin
      errors++;
      $display("FAIL R8: exceeds_o actual %b expected %b", exceeds_o, ovf_o);
    end
  endtask

  task automatic carry_pulse();
    carry_i = 1'b1; step(); carry_i = 1'b0; step();
  endtask

  task automatic latch_pulse();
    latch_i = 1'b1; step(); latch_i = 1'b0; step();
  endtask

  task automatic do_clear();
    clear_i = 1'b1; step(); clear_i = 1'b0;
  endtask

  task automatic t_reset();
    check("R1 reset ovf", ovf_o, 1'b0);
  endtask

  task automatic t_latch_release();
    manual_i = 1'b0;
    carry_pulse();
    check("R2 carry hidden before latch", ovf_o, 1'b0);
    check("R5 pre-stage not visible", ovf_o, 1'b0);
    latch_i = 1'b1; step();
    check("R3 still low while latch high", ovf_o, 1'b0);
    latch_i = 1'b0; step();
    check("R3 set after latch fall", ovf_o, 1'b1);
    do_clear();
    check("R6 clear", ovf_o, 1'b0);
  endtask

  task automatic t_manual();
    manual_i = 1'b1;
    carry_i = 1'b1; step();
    check("R4 manual immediate", ovf_o, 1'b1);
    carry_i = 1'b0; step();
    manual_i = 1'b0;
    #1;
    check("R5 manual off hides pre", ovf_o, 1'b0);
    latch_pulse();
    check("R3 release after manual", ovf_o, 1'b1);
    do_clear();
    check("R6 clear after manual", ovf_o, 1'b0);
  endtask

  task automatic t_no_carry();
    latch_pulse();
    latch_pulse();
    check("R9 latch without carry", ovf_o, 1'b0);
  endtask

  task automatic t_sticky();
    carry_pulse(); latch_pulse();
    carry_pulse(); carry_pulse(); latch_pulse(); latch_pulse();
    check("R7 sticky", ovf_o, 1'b1);
    do_clear();
    check("R6 clear sticky", ovf_o, 1'b0);
  endtask

  task automatic t_same_edge();
    latch_i = 1'b1; step();
    latch_i = 1'b0; carry_i = 1'b1; step();
    carry_i = 1'b0;
    check("R10 same edge takes old pre", ovf_o, 1'b0);
    step();
    latch_pulse();
    check("R10 next latch shows", ovf_o, 1'b1);
    do_clear();
  endtask

  task automatic t_clear_priority();
    clear_i = 1'b1; carry_i = 1'b1; step();
    clear_i = 1'b0; carry_i = 1'b0; step();
    latch_pulse();
    check("R6 clear beats carry", ovf_o, 1'b0);
    carry_pulse();
    latch_i = 1'b1; step();
    latch_i = 1'b0; clear_i = 1'b1; step();
    clear_i = 1'b0;
    check("R6 clear beats latch fall", ovf_o, 1'b0);
    latch_pulse();
    check("R6 pre-stage cleared too", ovf_o, 1'b0);
    manual_i = 1'b1; #1;
    check("R6 manual sees cleared pre", ovf_o, 1'b0);
    manual_i = 1'b0;
  endtask

  initial begin
    #4000000;
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    step();
    t_reset();
    t_latch_release();
    t_manual();
    t_no_carry();
    t_sticky();
    t_same_edge();
    t_clear_priority();
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule